// File: doc/BRIEF.md
# Tri-State Boundary Cell Array

This block holds the boundary conditions for a square grid of display nodes. Every node owns a small cell that is in one of three states: held at the positive level, held at the negative level, or left floating. A single touch port addresses one cell per clock cycle and carries a two-bit code. A positive or negative code fixes the cell to that level. The zero code releases the cell.

Two array-wide erase inputs, one for each polarity, wipe every cell of that polarity in one cycle. Each cell drives a two-bit status field on a flat output vector. A downstream field solver or lamp display reads these fields. A cell that already holds one level refuses a touch of the other level until it has been released, so the two levels can never be held together.

Top module: `bcell_array`

## Requirements
- R1: When `rst` is high at a rising edge, every cell becomes floating (status 2'b00) after that edge.
- R2: Touch code 2'b01 on a floating cell sets it to positive (status bit 0 set, status 2'b01) after the edge.
- R3: Touch code 2'b10 on a floating cell sets it to negative (status bit 1 set, status 2'b10) after the edge.
- R4: Touch code 2'b11 on a cell makes it floating after the edge, whatever it held, and leaves every other cell unchanged.
- R5: A touch of the opposite polarity on a cell that holds a level is ignored, and the cell keeps its level.
- R6: No cell status ever reads 2'b11.
- R7: `erase_pos` high at an edge clears every positive cell, and negative cells keep their level.
- R8: `erase_neg` high at an edge clears every negative cell, and positive cells keep their level.
- R9: `erase_pos` and `erase_neg` high together at an edge make the whole array floating.
- R10: An erase beats a touch of the same polarity aimed at a cell in the same cycle, so that cell ends up floating.
- R11: A touch reaches only the cell at linear index `touch_addr` = row*COLS+col, whose status sits at bits [2*index+1:2*index]. Code 2'b00 changes nothing, and no more than one cell is selected per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| touch_addr | input | ADDR_W (10) | Linear index of the touched cell |
| touch_code | input | 2 | 00 none, 01 positive, 10 negative, 11 release |
| erase_pos | input | 1 | Clear every positive cell |
| erase_neg | input | 1 | Clear every negative cell |
| clamp_state | output | 2*CELLS (2048) | Per-cell status, bit 0 positive, bit 1 negative |

## Verification
In every cell and on every cycle, the assertions check the interlock, the set, release and ignore rules for touches, the per-polarity erase effects, and that idle cells hold their state. The decoder select is checked to be one-hot or empty. Whole-array outcomes need the bench scenarios. These include a touch hitting the right cell and no neighbour, the both-erase wipe over a populated pattern, and the erase-versus-touch race on one cell. The bench compares every cell after every cycle.

// File: rtl/bcell_pkg.sv
package bcell_pkg;

    typedef enum logic [1:0] {
        TOUCH_NONE = 2'b00,
        TOUCH_POS  = 2'b01,
        TOUCH_NEG  = 2'b10,
        TOUCH_ZERO = 2'b11
    } touch_e;

    typedef struct packed {
        logic neg;
        logic pos;
    } clamp_t;

endpackage

// File: rtl/bcell_decode.sv
module bcell_decode #(
    parameter int CELLS  = 1024,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        code,
    output logic [CELLS-1:0]  hit
);
    import bcell_pkg::*;

    logic active;
    assign active = (code != TOUCH_NONE);

    for (genvar i = 0; i < CELLS; i++) begin : g_sel
        assign hit[i] = active && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/bcell_node.sv
module bcell_node (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [1:0] code,
    input  logic       erase_pos,
    input  logic       erase_neg,
    output logic [1:0] state
);
    import bcell_pkg::*;

    clamp_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (hit) begin
            case (code)
                TOUCH_POS:  if (!cell_q.neg) cell_d.pos = 1'b1;
                TOUCH_NEG:  if (!cell_q.pos) cell_d.neg = 1'b1;
                TOUCH_ZERO: cell_d = '0;
                default:    cell_d = cell_q;
            endcase
        end
        if (erase_pos) cell_d.pos = 1'b0;
        if (erase_neg) cell_d.neg = 1'b0;
        if (rst)       cell_d = '0;
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    assign state = cell_q;

    AST_RST_FLOAT: assert property (@(posedge clk) rst |=> (cell_q == '0)); // R1
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(cell_q.pos && cell_q.neg)); // R6
    AST_POS_SET: assert property (@(posedge clk) disable iff (rst)
        (hit && code == TOUCH_POS && !cell_q.neg && !erase_pos) |=> cell_q.pos); // R2
    AST_NEG_SET: assert property (@(posedge clk) disable iff (rst)
        (hit && code == TOUCH_NEG && !cell_q.pos && !erase_neg) |=> cell_q.neg); // R3
    AST_ZERO_CLR: assert property (@(posedge clk) disable iff (rst)
        (hit && code == TOUCH_ZERO) |=> (cell_q == '0)); // R4
    AST_OPP_IGN_P: assert property (@(posedge clk) disable iff (rst)
        (hit && code == TOUCH_NEG && cell_q.pos && !erase_pos) |=> (cell_q.pos && !cell_q.neg)); // R5
    AST_OPP_IGN_N: assert property (@(posedge clk) disable iff (rst)
        (hit && code == TOUCH_POS && cell_q.neg && !erase_neg) |=> (cell_q.neg && !cell_q.pos)); // R5
    AST_ERASE_POS: assert property (@(posedge clk) disable iff (rst)
        erase_pos |=> !cell_q.pos); // R7
    AST_KEEP_NEG: assert property (@(posedge clk) disable iff (rst)
        (erase_pos && !erase_neg && cell_q.neg && !(hit && code == TOUCH_ZERO)) |=> cell_q.neg); // R7
    AST_ERASE_NEG: assert property (@(posedge clk) disable iff (rst)
        erase_neg |=> !cell_q.neg); // R8
    AST_KEEP_POS: assert property (@(posedge clk) disable iff (rst)
        (erase_neg && !erase_pos && cell_q.pos && !(hit && code == TOUCH_ZERO)) |=> cell_q.pos); // R8
    AST_BOTH_WIPE: assert property (@(posedge clk) disable iff (rst)
        (erase_pos && erase_neg) |=> (cell_q == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hit && !erase_pos && !erase_neg) |=> $stable(cell_q)); // R11

endmodule

// File: rtl/bcell_array.sv
module bcell_array #(
    parameter  int ROWS   = 32,
    parameter  int COLS   = 32,
    localparam int CELLS  = ROWS * COLS,
    localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   touch_addr,
    input  logic [1:0]          touch_code,
    input  logic                erase_pos,
    input  logic                erase_neg,
    output logic [2*CELLS-1:0]  clamp_state
);

    logic [CELLS-1:0] hit;

    bcell_decode #(
        .CELLS  (CELLS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (touch_addr),
        .code (touch_code),
        .hit  (hit)
    );

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        bcell_node u_node (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit[i]),
            .code      (touch_code),
            .erase_pos (erase_pos),
            .erase_neg (erase_neg),
            .state     (clamp_state[2*i +: 2])
        );
    end

    AST_ONE_TOUCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R11

endmodule

// File: tb/bcell_array_test.sv
module bcell_array_test;

    localparam int ROWS   = 32;
    localparam int COLS   = 32;
    localparam int CELLS  = ROWS * COLS;
    localparam int ADDR_W = $clog2(CELLS);
    localparam int W      = 2 * CELLS;

    typedef struct {
        int           req;
        logic [W-1:0] exp;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] touch_addr = '0;
    logic [1:0]        touch_code = 2'b00;
    logic              erase_pos = 1'b0;
    logic              erase_neg = 1'b0;
    logic [W-1:0]      clamp_state;

    int checks = 0;
    int errors = 0;
    item_t        sb_q[$];
    logic [W-1:0] mdl = '0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    bcell_array #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk         (clk),
        .rst         (rst),
        .touch_addr  (touch_addr),
        .touch_code  (touch_code),
        .erase_pos   (erase_pos),
        .erase_neg   (erase_neg),
        .clamp_state (clamp_state)
    );

    // Drive one cycle at the falling edge and queue the state expected after the next rising edge.
    task automatic step(input int req, input int addr, input logic [1:0] code,
                        input logic ep, input logic en, input logic r);
        item_t it;
        @(negedge clk);
        rst        = r;
        touch_addr = ADDR_W'(addr);
        touch_code = code;
        erase_pos  = ep;
        erase_neg  = en;
        if (r) begin
            mdl = '0;
        end else begin
            logic [1:0] c;
            c = mdl[2*addr +: 2];
            case (code)
                2'b01: if (!c[1]) c[0] = 1'b1;
                2'b10: if (!c[0]) c[1] = 1'b1;
                2'b11: c = 2'b00;
                default: ;
            endcase
            mdl[2*addr +: 2] = c;
            for (int i = 0; i < CELLS; i++) begin
                if (ep) mdl[2*i]   = 1'b0;
                if (en) mdl[2*i+1] = 1'b0;
            end
        end
        it.req = req;
        it.exp = mdl;
        sb_q.push_back(it);
    endtask

    // Monitor: compares the whole array shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (clamp_state !== it.exp) begin
                errors++;
                for (int i = 0; i < CELLS; i++) begin
                    if (clamp_state[2*i +: 2] !== it.exp[2*i +: 2]) begin
                        $display("FAIL R%0d cell %0d actual %b expected %b",
                                 it.req, i, clamp_state[2*i +: 2], it.exp[2*i +: 2]);
                        break;
                    end
                end
            end
            for (int i = 0; i < CELLS; i++) begin
                if (clamp_state[2*i +: 2] === 2'b11) begin
                    errors++;
                    $display("FAIL R6 cell %0d actual 11 expected not 11", i);
                    break;
                end
            end
        end
    end

    initial begin
        step(1, 0, 2'b00, 0, 0, 1);        // R1 reset
        step(1, 0, 2'b00, 0, 0, 1);        // R1
        step(11, 7, 2'b00, 0, 0, 0);       // R11 idle code
        step(2, 5, 2'b01, 0, 0, 0);        // R2
        step(3, 1023, 2'b10, 0, 0, 0);     // R3 last cell
        step(2, 0, 2'b01, 0, 0, 0);        // R2 first cell
        step(3, 41, 2'b10, 0, 0, 0);       // R3
        step(2, 40, 2'b01, 0, 0, 0);       // R2 neighbour
        step(11, 100, 2'b00, 0, 0, 0);     // R11 none code
        step(5, 5, 2'b10, 0, 0, 0);        // R5 negative on positive
        step(5, 1023, 2'b01, 0, 0, 0);     // R5 positive on negative
        step(4, 40, 2'b11, 0, 0, 0);       // R4 release positive
        step(4, 41, 2'b11, 0, 0, 0);       // R4 release negative
        step(4, 300, 2'b11, 0, 0, 0);      // R4 release floating
        step(2, 40, 2'b01, 0, 0, 0);       // R2 after release
        step(7, 0, 2'b00, 1, 0, 0);        // R7 positive wipe
        step(2, 5, 2'b01, 0, 0, 0);        // R2
        step(8, 0, 2'b00, 0, 1, 0);        // R8 negative wipe
        step(3, 1023, 2'b10, 0, 0, 0);     // R3 after wipe
        step(10, 64, 2'b01, 1, 0, 0);      // R10 erase beats positive touch
        step(10, 65, 2'b10, 0, 1, 0);      // R10 erase beats negative touch
        step(10, 66, 2'b10, 1, 0, 0);      // R10 other-polarity erase leaves the touch
        for (int k = 0; k < 96; k++) begin
            step((k % 2 == 0) ? 2 : 3, (k * 37 + 3) % CELLS, (k % 2 == 0) ? 2'b01 : 2'b10, 0, 0, 0); // R2 R3 pattern
        end
        for (int k = 0; k < 16; k++) begin
            step(5, (k * 74 + 3) % CELLS, 2'b10, 0, 0, 0); // R5 on pattern
        end
        step(7, 0, 2'b00, 1, 0, 0);        // R7 on pattern
        for (int k = 0; k < 32; k++) begin
            step(2, (k * 29 + 11) % CELLS, 2'b01, 0, 0, 0); // R2 refill
        end
        step(9, 0, 2'b00, 1, 1, 0);        // R9 both wipe
        step(1, 5, 2'b01, 0, 0, 0);        // R2 before reset
        step(1, 0, 2'b00, 0, 0, 1);        // R1 reset mid-run
        step(11, 0, 2'b00, 0, 0, 0);       // R11
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule